// File: doc/BRIEF.md
# BCD Clock Calendar Core with Hundredths

This block keeps time and date as binary-coded decimal. The fields are hundredths of a second, seconds, minutes, hours, day of week, date, month and two-digit year. A tick-enable input pulses at a fixed rate. A parameterised phase counter turns each group of `TICKS_PER_STEP` pulses into one hundredth-of-a-second step. Each step ripples carries through every field in the same clock. The carry chain applies month lengths, leap Februaries, a 12-hour or 24-hour hour format, and a seven-day weekday cycle.

All state is presented as eight bytes on one flat snapshot output, so a serial access controller can shift any register out. The same controller loads whole registers through a simple write strobe with a register select and a data byte. A control byte holds a run/stop flag for the counting and a reset-enable flag. The core only stores the reset-enable flag for its neighbour.

Top module: `ccal_core`

## Requirements
- R1: After reset the snapshot bytes 0..7 read 00, 00, 00, 00, 21, 01, 01, 00. The core starts stopped, in 24-hour mode, at day 1, date 01, month 01, year 00.
- R2: While byte 4 bit 5 is 0, byte 0 (hundredths, tens of the hundredths value in bits 7:4) advances by one BCD step on every `TICKS_PER_STEP`-th tick pulse. The other pulses change nothing. 99 wraps to 00 with a carry into byte 1 (seconds). 59 wraps to 00 with a carry into byte 2 (minutes), and minutes carry into the hours the same way.
- R3: While byte 4 bit 5 is 1, tick pulses change neither any register nor the tick phase.
- R4: With byte 3 bit 7 at 0 (24-hour mode), hours count 00..23 with bit 5 as the second tens bit. 23 wraps to 00 and carries into the day.
- R5: With byte 3 bit 7 at 1 (12-hour mode), bit 5 is PM. Hour 11 steps to 12 and toggles PM, and 12 steps to 01. Only the 11 PM to 12 AM step carries into the day.
- R6: A day carry advances byte 4 bits 2:0 (weekday, 7 wraps to 1) and byte 5 (date).
- R7: The date wraps to 01 and the month (byte 6) advances after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months. In February this happens after 29 when the BCD year is a multiple of four, else after 28.
- R8: Month 12 wraps to 01 and increments byte 7 (year), and year 99 wraps to 00.
- R9: Unused bits read 0 whatever was written: byte 1 bit 7, byte 2 bit 7, byte 3 bit 6, byte 4 bits 7, 6 and 3, byte 5 bits 7:6, byte 6 bits 7:5.
- R10: A write loads the selected register in the same clock. Any counting step due in that clock is dropped for every register.
- R11: A write to byte 0 resets the tick phase. The next step needs a full `TICKS_PER_STEP` pulses.
- R12: Byte 4 bit 4 (reset-enable) keeps its written value and is never altered by counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase pulse, one clock wide per pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register number to write (0..7) |
| wr_byte | input | 8 | Data for the written register |
| snap | output | 64 | All eight registers, register k on bits 8k+7:8k |

## Verification
On every clock, the embedded properties check several local cycle-to-cycle rules. A stopped core holds its snapshot. A write reaches its target and leaves hundredths untouched. The PM flag flips at the 11-to-12 step. The weekday and year wrap correctly, the phase counter clears on a byte-0 write, and the reset-enable bit changes only by a write. The longer-range behaviour can only be shown by the directed scenarios: the month-length and leap-year table across many months and years, a full cascade from 23:59:59.99 on 31 December 99, the 12-hour sequence including midnight, and the exact tick count between steps after a phase reset, after a stop and restart, and after a dropped step.

// File: rtl/ccal_pkg.sv
`timescale 1ns/1ps
package ccal_pkg;

   localparam int unsigned REG_W    = 8;
   localparam int unsigned NUM_REGS = 8;
   localparam int unsigned SEL_W    = $clog2(NUM_REGS);

   localparam logic [SEL_W-1:0] IDX_CENT  = 3'd0;
   localparam logic [SEL_W-1:0] IDX_SEC   = 3'd1;
   localparam logic [SEL_W-1:0] IDX_MIN   = 3'd2;
   localparam logic [SEL_W-1:0] IDX_HOUR  = 3'd3;
   localparam logic [SEL_W-1:0] IDX_CTRL  = 3'd4;
   localparam logic [SEL_W-1:0] IDX_DATE  = 3'd5;
   localparam logic [SEL_W-1:0] IDX_MONTH = 3'd6;
   localparam logic [SEL_W-1:0] IDX_YEAR  = 3'd7;

   // one decimal digit step, 9 rolls to 0
   function automatic logic [3:0] nib_next(input logic [3:0] u);
      return (u == 4'd9) ? 4'd0 : u + 4'd1;
   endfunction

   function automatic logic nib_is9(input logic [3:0] u);
      return u == 4'd9;
   endfunction

   // multiple of four: even tens with units 0/4/8, odd tens with units 2/6
   function automatic logic year_is_leap(input logic tens_odd, input logic [3:0] u);
      if (tens_odd) return (u == 4'd2) || (u == 4'd6);
      return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
   endfunction

   function automatic logic [7:0] month_last_day(input logic [4:0] mon, input logic leap);
      case (mon)
         5'h02:                      return leap ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/ccal_prescale.sv
`timescale 1ns/1ps
module ccal_prescale #(
   parameter int unsigned TICKS_PER_STEP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   input  logic clear,
   output logic step
);

   initial begin
      assert (TICKS_PER_STEP >= 1)
         else $fatal(1, "ccal_prescale: TICKS_PER_STEP must be at least 1");
   end

   generate
      if (TICKS_PER_STEP == 1) begin : g_direct
         assign step = run & tick;
      end else begin : g_count
         localparam int unsigned CW = $clog2(TICKS_PER_STEP);
         localparam logic [CW-1:0] LAST = CW'(TICKS_PER_STEP - 1);

         logic [CW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               phase_q <= '0;
            else if (clear)
               phase_q <= '0;
            else if (run && tick)
               phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
         end

         assign step = run & tick & (phase_q == LAST);

         p_phase_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> (phase_q == '0));

         p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !clear) |=> $stable(phase_q));
      end
   endgenerate

endmodule

// File: rtl/ccal_clock_chain.sv
`timescale 1ns/1ps
module ccal_clock_chain
   import ccal_pkg::*;
#(
   parameter bit RESET_MODE12 = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [REG_W-1:0] wr_byte,
   output logic [REG_W-1:0] cent_o,
   output logic [REG_W-1:0] sec_o,
   output logic [REG_W-1:0] min_o,
   output logic [REG_W-1:0] hour_o,
   output logic             day_carry
);

   logic [7:0] cent_q;
   logic [6:0] sec_q;
   logic [6:0] min_q;
   logic       mode12_q;
   logic       b5_q;
   logic [4:0] hr_q;

   logic [7:0] cent_n;
   logic [6:0] sec_n;
   logic [6:0] min_n;
   logic [4:0] hr_n;
   logic       b5_n;
   logic       hour_carry;
   logic [1:0] tens2;

   logic cent_wrap, sec_wrap, min_wrap;
   logic sec_adv, min_adv, hr_adv;

   assign cent_wrap = (cent_q == 8'h99);
   assign sec_wrap  = (sec_q  == 7'h59);
   assign min_wrap  = (min_q  == 7'h59);

   assign sec_adv   = adv & cent_wrap;
   assign min_adv   = sec_adv & sec_wrap;
   assign hr_adv    = min_adv & min_wrap;
   assign day_carry = hr_adv & hour_carry;

   always_comb begin
      cent_n = cent_wrap ? 8'h00
             : {cent_q[7:4] + {3'b000, nib_is9(cent_q[3:0])}, nib_next(cent_q[3:0])};
      sec_n  = sec_wrap ? 7'h00
             : {sec_q[6:4] + {2'b00, nib_is9(sec_q[3:0])}, nib_next(sec_q[3:0])};
      min_n  = min_wrap ? 7'h00
             : {min_q[6:4] + {2'b00, nib_is9(min_q[3:0])}, nib_next(min_q[3:0])};
   end

   always_comb begin
      hr_n       = hr_q;
      b5_n       = b5_q;
      hour_carry = 1'b0;
      tens2      = 2'b00;
      if (mode12_q) begin
         if (hr_q == 5'h11) begin
            hr_n       = 5'h12;
            b5_n       = ~b5_q;
            hour_carry = b5_q;
         end else if (hr_q == 5'h12) begin
            hr_n = 5'h01;
         end else begin
            hr_n = {hr_q[4] | nib_is9(hr_q[3:0]), nib_next(hr_q[3:0])};
         end
      end else begin
         if ({b5_q, hr_q} == 6'h23) begin
            hr_n       = 5'h00;
            b5_n       = 1'b0;
            hour_carry = 1'b1;
         end else begin
            tens2 = {b5_q, hr_q[4]} + {1'b0, nib_is9(hr_q[3:0])};
            b5_n  = tens2[1];
            hr_n  = {tens2[0], nib_next(hr_q[3:0])};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cent_q   <= 8'h00;
         sec_q    <= 7'h00;
         min_q    <= 7'h00;
         mode12_q <= RESET_MODE12;
         b5_q     <= 1'b0;
         hr_q     <= RESET_MODE12 ? 5'h12 : 5'h00;
      end else if (wr_en) begin
         case (wr_sel)
            IDX_CENT: cent_q <= wr_byte;
            IDX_SEC:  sec_q  <= wr_byte[6:0];
            IDX_MIN:  min_q  <= wr_byte[6:0];
            IDX_HOUR: begin
               mode12_q <= wr_byte[7];
               b5_q     <= wr_byte[5];
               hr_q     <= wr_byte[4:0];
            end
            default: ;
         endcase
      end else begin
         if (adv)     cent_q <= cent_n;
         if (sec_adv) sec_q  <= sec_n;
         if (min_adv) min_q  <= min_n;
         if (hr_adv) begin
            hr_q <= hr_n;
            b5_q <= b5_n;
         end
      end
   end

   assign cent_o = cent_q;
   assign sec_o  = {1'b0, sec_q};
   assign min_o  = {1'b0, min_q};
   assign hour_o = {mode12_q, 1'b0, b5_q, hr_q};

   p_cent_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !wr_en && !cent_wrap) |=> (cent_q != $past(cent_q)) && $stable(sec_q));

   p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == IDX_CENT) |=> (cent_q == $past(wr_byte)));

   p_pm_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hr_adv && !wr_en && mode12_q && hr_q == 5'h11) |=> (b5_q != $past(b5_q)));

   p_midnight_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hr_adv && !wr_en && !mode12_q && b5_q && hr_q == 5'h03) |=> (!b5_q && hr_q == 5'h00));

endmodule

// File: rtl/ccal_cal_chain.sv
`timescale 1ns/1ps
module ccal_cal_chain
   import ccal_pkg::*;
#(
   parameter bit RESET_OSC_OFF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             day_adv,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [REG_W-1:0] wr_byte,
   output logic [REG_W-1:0] ctrl_o,
   output logic [REG_W-1:0] date_o,
   output logic [REG_W-1:0] month_o,
   output logic [REG_W-1:0] year_o,
   output logic             osc_off_o
);

   logic [2:0] dow_q;
   logic       rsten_q;
   logic       osc_q;
   logic [5:0] date_q;
   logic [4:0] month_q;
   logic [7:0] year_q;

   logic       leap;
   logic [7:0] last_day;
   logic       date_wrap, month_wrap;
   logic       mon_adv, yr_adv;
   logic [2:0] dow_n;
   logic [5:0] date_n;
   logic [4:0] month_n;
   logic [7:0] year_n;

   assign leap       = year_is_leap(year_q[4], year_q[3:0]);
   assign last_day   = month_last_day(month_q, leap);
   assign date_wrap  = ({2'b00, date_q} >= last_day);
   assign month_wrap = (month_q == 5'h12);
   assign mon_adv    = day_adv & date_wrap;
   assign yr_adv     = mon_adv & month_wrap;

   always_comb begin
      dow_n   = (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      date_n  = date_wrap ? 6'h01
              : {date_q[5:4] + {1'b0, nib_is9(date_q[3:0])}, nib_next(date_q[3:0])};
      month_n = month_wrap ? 5'h01
              : {month_q[4] | nib_is9(month_q[3:0]), nib_next(month_q[3:0])};
      year_n  = (year_q == 8'h99) ? 8'h00
              : {year_q[7:4] + {3'b000, nib_is9(year_q[3:0])}, nib_next(year_q[3:0])};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dow_q   <= 3'd1;
         rsten_q <= 1'b0;
         osc_q   <= RESET_OSC_OFF;
         date_q  <= 6'h01;
         month_q <= 5'h01;
         year_q  <= 8'h00;
      end else if (wr_en) begin
         case (wr_sel)
            IDX_CTRL: begin
               dow_q   <= wr_byte[2:0];
               rsten_q <= wr_byte[4];
               osc_q   <= wr_byte[5];
            end
            IDX_DATE:  date_q  <= wr_byte[5:0];
            IDX_MONTH: month_q <= wr_byte[4:0];
            IDX_YEAR:  year_q  <= wr_byte;
            default: ;
         endcase
      end else begin
         if (day_adv) begin
            dow_q  <= dow_n;
            date_q <= date_n;
         end
         if (mon_adv) month_q <= month_n;
         if (yr_adv)  year_q  <= year_n;
      end
   end

   assign ctrl_o    = {2'b00, osc_q, rsten_q, 1'b0, dow_q};
   assign date_o    = {2'b00, date_q};
   assign month_o   = {3'b000, month_q};
   assign year_o    = year_q;
   assign osc_off_o = osc_q;

   p_dow_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (day_adv && !wr_en && dow_q == 3'd7) |=> (dow_q == 3'd1));

   p_month_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (day_adv && !wr_en && date_wrap) |=> (month_q != $past(month_q)));

   p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (yr_adv && !wr_en && year_q == 8'h99) |=> (year_q == 8'h00));

   p_ctrl_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == IDX_CTRL) |=> ($stable(rsten_q) && $stable(osc_q)));

endmodule

// File: rtl/ccal_core.sv
`timescale 1ns/1ps
module ccal_core
   import ccal_pkg::*;
#(
   parameter int unsigned TICKS_PER_STEP = 4,
   parameter bit          RESET_MODE12   = 1'b0,
   parameter bit          RESET_OSC_OFF  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick_en,
   input  logic                      wr_en,
   input  logic [2:0]                wr_sel,
   input  logic [7:0]                wr_byte,
   output logic [NUM_REGS*REG_W-1:0] snap
);

   logic             osc_off;
   logic             step;
   logic             step_ok;
   logic             phase_clr;
   logic             day_carry;
   logic [REG_W-1:0] regs [NUM_REGS];

   assign phase_clr = wr_en && (wr_sel == IDX_CENT);
   assign step_ok   = step & ~wr_en;

   ccal_prescale #(
      .TICKS_PER_STEP(TICKS_PER_STEP)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (~osc_off),
      .tick  (tick_en),
      .clear (phase_clr),
      .step  (step)
   );

   ccal_clock_chain #(
      .RESET_MODE12(RESET_MODE12)
   ) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (step_ok),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_byte   (wr_byte),
      .cent_o    (regs[IDX_CENT]),
      .sec_o     (regs[IDX_SEC]),
      .min_o     (regs[IDX_MIN]),
      .hour_o    (regs[IDX_HOUR]),
      .day_carry (day_carry)
   );

   ccal_cal_chain #(
      .RESET_OSC_OFF(RESET_OSC_OFF)
   ) u_cal (
      .clk       (clk),
      .rst_n     (rst_n),
      .day_adv   (day_carry),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_byte   (wr_byte),
      .ctrl_o    (regs[IDX_CTRL]),
      .date_o    (regs[IDX_DATE]),
      .month_o   (regs[IDX_MONTH]),
      .year_o    (regs[IDX_YEAR]),
      .osc_off_o (osc_off)
   );

   generate
      for (genvar k = 0; k < NUM_REGS; k++) begin : g_snap
         assign snap[k*REG_W +: REG_W] = regs[k];
      end
   endgenerate

   p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_off && !wr_en) |=> $stable(snap));

   p_write_drops_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != IDX_CENT) |=> $stable(snap[REG_W-1:0]));

endmodule

// File: tb/sim_ccal_core.sv
`timescale 1ns/1ps
module sim_ccal_core;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_en;
   logic        wr_en;
   logic [2:0]  wr_sel;
   logic [7:0]  wr_byte;
   logic [63:0] snap;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   ccal_core u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_byte (wr_byte),
      .snap    (snap)
   );

   task automatic chk(input string req, input int idx, input logic [7:0] exp);
      logic [7:0] got;
      got = snap[idx*8 +: 8];
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s reg%0d got %02h expected %02h", req, idx, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_byte = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
      end
      tick_en = 1'b0;
   endtask

   task automatic tick_and_write(input logic [2:0] sel, input logic [7:0] d);
      tick_en = 1'b1; wr_en = 1'b1; wr_sel = sel; wr_byte = d;
      @(negedge clk);
      tick_en = 1'b0; wr_en = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] c, input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] ctl, input logic [7:0] dt,
                           input logic [7:0] mo, input logic [7:0] yr);
      wr(3'd4, ctl); wr(3'd1, s); wr(3'd2, m); wr(3'd3, h);
      wr(3'd5, dt);  wr(3'd6, mo); wr(3'd7, yr); wr(3'd0, c);
   endtask

   task automatic t_reset;
      chk("R1", 0, 8'h00); chk("R1", 1, 8'h00); chk("R1", 2, 8'h00); chk("R1", 3, 8'h00);
      chk("R1", 4, 8'h21); chk("R1", 5, 8'h01); chk("R1", 6, 8'h01); chk("R1", 7, 8'h00);
      pulse(9);
      chk("R3", 0, 8'h00);
   endtask

   task automatic t_full_cascade;
      set_time(8'h98, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
      pulse(3);
      chk("R2", 0, 8'h98);
      pulse(1);
      chk("R2", 0, 8'h99); chk("R2", 1, 8'h59);
      pulse(4);
      chk("R2", 0, 8'h00); chk("R2", 1, 8'h00); chk("R2", 2, 8'h00);
      chk("R4", 3, 8'h00); chk("R6", 4, 8'h01); chk("R6", 5, 8'h01);
      chk("R8", 6, 8'h01); chk("R8", 7, 8'h00);
      pulse(3);
      chk("R2", 0, 8'h00);
      pulse(1);
      chk("R2", 0, 8'h01);
   endtask

   task automatic t_hours24;
      set_time(8'h99, 8'h59, 8'h59, 8'h09, 8'h03, 8'h10, 8'h05, 8'h30);
      pulse(4);
      chk("R4", 3, 8'h10); chk("R4", 4, 8'h03);
      set_time(8'h99, 8'h59, 8'h59, 8'h19, 8'h03, 8'h10, 8'h05, 8'h30);
      pulse(4);
      chk("R4", 3, 8'h20); chk("R4", 5, 8'h10);
   endtask

   task automatic t_hours12;
      set_time(8'h99, 8'h59, 8'h59, 8'h91, 8'h01, 8'h15, 8'h06, 8'h24);
      pulse(4);
      chk("R5", 3, 8'hB2); chk("R5", 4, 8'h01); chk("R5", 5, 8'h15);
      set_time(8'h99, 8'h59, 8'h59, 8'hB2, 8'h01, 8'h15, 8'h06, 8'h24);
      pulse(4);
      chk("R5", 3, 8'hA1); chk("R5", 5, 8'h15);
      set_time(8'h99, 8'h59, 8'h59, 8'hB1, 8'h01, 8'h15, 8'h06, 8'h24);
      pulse(4);
      chk("R5", 3, 8'h92); chk("R5", 4, 8'h02); chk("R5", 5, 8'h16);
   endtask

   task automatic month_end(input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr,
                            input logic [7:0] exp_dt, input logic [7:0] exp_mo);
      set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, dt, mo, yr);
      pulse(4);
      chk("R7", 5, exp_dt);
      chk("R7", 6, exp_mo);
   endtask

   task automatic t_months;
      month_end(8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
      month_end(8'h30, 8'h09, 8'h23, 8'h01, 8'h10);
      month_end(8'h30, 8'h11, 8'h23, 8'h01, 8'h12);
      month_end(8'h30, 8'h01, 8'h23, 8'h31, 8'h01);
      month_end(8'h31, 8'h01, 8'h23, 8'h01, 8'h02);
      month_end(8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
      month_end(8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
      month_end(8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
      month_end(8'h29, 8'h02, 8'h00, 8'h01, 8'h03);
      month_end(8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
      month_end(8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
   endtask

   task automatic t_unused_bits;
      wr(3'd4, 8'hFF);
      chk("R9", 4, 8'h37);
      wr(3'd1, 8'hFF); chk("R9", 1, 8'h7F);
      wr(3'd2, 8'hFF); chk("R9", 2, 8'h7F);
      wr(3'd3, 8'hFF); chk("R9", 3, 8'hBF);
      wr(3'd5, 8'hFF); chk("R9", 5, 8'h3F);
      wr(3'd6, 8'hFF); chk("R9", 6, 8'h1F);
   endtask

   task automatic t_write_priority;
      set_time(8'h40, 8'h10, 8'h10, 8'h10, 8'h01, 8'h05, 8'h05, 8'h05);
      pulse(3);
      tick_and_write(3'd1, 8'h33);
      chk("R10", 0, 8'h40); chk("R10", 1, 8'h33);
      pulse(3);
      chk("R10", 0, 8'h40);
      pulse(1);
      chk("R10", 0, 8'h41);
   endtask

   task automatic t_phase_clear;
      set_time(8'h10, 8'h10, 8'h10, 8'h10, 8'h01, 8'h05, 8'h05, 8'h05);
      pulse(2);
      wr(3'd0, 8'h20);
      pulse(3);
      chk("R11", 0, 8'h20);
      pulse(1);
      chk("R11", 0, 8'h21);
      pulse(3);
      tick_and_write(3'd0, 8'h55);
      chk("R11", 0, 8'h55);
      pulse(3);
      chk("R11", 0, 8'h55);
      pulse(1);
      chk("R11", 0, 8'h56);
   endtask

   task automatic t_stop;
      set_time(8'h20, 8'h10, 8'h10, 8'h10, 8'h01, 8'h05, 8'h05, 8'h05);
      pulse(2);
      wr(3'd4, 8'h21);
      pulse(5);
      chk("R3", 0, 8'h20); chk("R3", 4, 8'h21);
      wr(3'd4, 8'h01);
      pulse(1);
      chk("R3", 0, 8'h20);
      pulse(1);
      chk("R3", 0, 8'h21);
   endtask

   task automatic t_reset_enable;
      set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h17, 8'h09, 8'h09, 8'h09);
      pulse(4);
      chk("R12", 4, 8'h11);
      chk("R12", 5, 8'h10);
   endtask

   initial begin
      rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_sel = 3'd0; wr_byte = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_cascade();
      t_hours24();
      t_hours12();
      t_months();
      t_unused_bits();
      t_write_priority();
      t_phase_clear();
      t_stop();
      t_reset_enable();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: all requirements, got hung run expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule